// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers words between a write clock domain and an unrelated read clock domain. Each domain keeps its own binary pointer. Each pointer passes to the other domain as gray code through a two-stage synchroniser. The write side reports full and half-full. The read side reports empty, or output-ready when fall-through timing is used. An almost-empty and an almost-full flag compare the fill level against two offsets. These offsets come from one of eight presets at master reset. They can later be overwritten from the data bus or through a one-bit serial input.

Two output timings are available, both selected during master reset. In standard timing, data reaches the output only on a read request, and the read flag means empty. In fall-through timing, the oldest word appears on the output by itself, the read flag means a word is present, and the write flag means there is room. A partial reset empties the FIFO but keeps the offsets and the latched modes. A retransmit pulse sends reading back to the first location written since reset.

Top module: `dcfifo_pflags`

## Requirements
- R1: Words leave in the order they were written, with writes on `wclk` and reads on `rclk` running concurrently. The write pointer crosses domains as gray code, changing at most one bit per write-clock cycle.
- R2: In standard timing, `rflag` is high (empty) while no word is stored. A read accepted at an `rclk` edge updates `dout` at that same edge. A read while empty leaves `dout` and the read pointer unchanged.
- R3: `wflag` (standard timing) is high once DEPTH words are stored. A write while full is dropped and is not stored.
- R4: `hf` is high when the write-side count exceeds DEPTH/2.
- R5: Master reset sets both offsets to (preset_sel+1)*DEPTH/16. `pae` is high when the read-side count is at most the empty offset. `paf` is high when the write-side count is at least DEPTH minus the full offset.
- R6: With `ld` high, each `wen` cycle writes `din[AW-1:0]` into an offset instead of the FIFO. The first such cycle writes the empty offset and the next writes the full offset, alternating after that.
- R7: With `ld` high and `sen` high, `si` shifts into bit 0 of the concatenation {empty offset, full offset}. After 2*AW shifts, the first bit sent is the empty offset's MSB.
- R8: In fall-through timing, the oldest word appears on `dout` with no read request and `rflag` goes high (ready). A read consumes it and `rflag` falls when nothing remains. `wflag` is high while not full. The flag counts cover the array only, not the output word.
- R9: `mrst` clears data, reloads the preset offsets and latches `fwft_sel` and `flag_async_sel`. `prst` clears data but keeps the offsets and the latched modes.
- R10: `rt` on an `rclk` edge returns reading to location 0, so the stored words are read again from the first one. The write pointer is untouched. This holds while no more than DEPTH words have been written since reset.
- R11: In synchronous flag timing, `paf` and `pae` use the synchronised opposite pointer, so they change two or more local clock edges later. In asynchronous flag timing, they use the opposite pointer directly and follow it without waiting for a local edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high |
| prst | input | 1 | Partial reset, active high |
| fwft_sel | input | 1 | Fall-through timing select, latched in master reset |
| flag_async_sel | input | 1 | Asynchronous almost-flag timing select, latched in master reset |
| preset_sel | input | 3 | Default offset select |
| wen | input | 1 | Write enable |
| din | input | DW | Write data / parallel offset value |
| ld | input | 1 | Offset load mode |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset data |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit |
| dout | output | DW | Read data |
| rflag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wflag | output | 1 | Full (standard) or input-ready (fall-through) |
| hf | output | 1 | Half-full |
| pae | output | 1 | Almost empty |
| paf | output | 1 | Almost full |

## Verification
The assertions check on every clock that:
- a full write or an empty read never moves a pointer;
- the write-side gray code steps by one bit at most;
- full always implies half-full and, in synchronous timing, almost-full;
- a presented fall-through word holds until it is read;
- master reset latches the requested mode.

Only the directed scenarios can show the rest:
- data order and the exact fill counts at which each flag turns;
- the preset, parallel and serial offset values;
- the survival of offsets and mode across partial reset;
- the replay after retransmit;
- the different flag latency of the two flag timings.

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          flag_async_sel,
  input  logic [2:0]    preset_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          rflag,
  output logic          wflag,
  output logic          hf,
  output logic          pae,
  output logic          paf
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic fwft, fasync;
  logic [AW-1:0] ae_off, af_off;
  logic ld_sel;
  logic [PW-1:0] wbin, wgray, rbin, rgray, rg_s1, rg_s2, wg_s1, wg_s2;
  logic ovalid;
  logic [DW-1:0] q;

  wire pr = mrst | prst;
  wire [AW-1:0] def_off = AW'((32'(preset_sel) + 32'd1) << (AW - 4));

  always_ff @(posedge wclk)
    if (mrst) begin
      fwft   <= fwft_sel;
      fasync <= flag_async_sel;
    end

  always_ff @(posedge wclk)
    if (mrst) begin
      ae_off <= def_off;
      af_off <= def_off;
      ld_sel <= 1'b0;
    end else if (prst) begin
      ld_sel <= 1'b0;
    end else if (ld && wen) begin
      if (!ld_sel) ae_off <= din[AW-1:0];
      else         af_off <= din[AW-1:0];
      ld_sel <= ~ld_sel;
    end else if (ld && sen) begin
      {ae_off, af_off} <= {ae_off[AW-2:0], af_off, si};
    end

  // write domain
  wire [PW-1:0] rbin_ws = g2b(rg_s2);
  wire [PW-1:0] wcnt_s  = wbin - rbin_ws;
  wire [PW-1:0] wcnt    = wbin - (fasync ? rbin : rbin_ws);
  wire          full    = wcnt_s[AW];
  wire          wr_ok   = wen && !ld && !full;

  always_ff @(posedge wclk or posedge pr)
    if (pr) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= din;

  assign hf    = wcnt_s > PW'(DEPTH / 2);
  assign paf   = wcnt >= PW'(DEPTH) - {1'b0, af_off};
  assign wflag = fwft ? ~full : full;

  // read domain
  wire [PW-1:0] wbin_rs   = g2b(wg_s2);
  wire [PW-1:0] rcnt      = (fasync ? wbin : wbin_rs) - rbin;
  wire          ram_empty = (wbin_rs == rbin);
  wire          fetch     = fwft ? ((!ovalid || ren) && !ram_empty) : (ren && !ram_empty);

  always_ff @(posedge rclk or posedge pr)
    if (pr) begin
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      ovalid <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rt) begin
        rbin   <= '0;
        rgray  <= '0;
        ovalid <= 1'b0;
      end else begin
        if (fetch) begin
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
        end
        if (fetch)    ovalid <= 1'b1;
        else if (ren) ovalid <= 1'b0;
      end
    end

  always_ff @(posedge rclk)
    if (fetch && !rt) q <= mem[rbin[AW-1:0]];

  assign dout  = q;
  assign rflag = fwft ? ovalid : ram_empty;
  assign pae   = rcnt <= {1'b0, ae_off};
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          fwft_sel,
  input logic          wen,
  input logic          ren,
  input logic          rt,
  input logic          full,
  input logic          hf,
  input logic          paf,
  input logic          fasync,
  input logic          fwft,
  input logic          ovalid,
  input logic          ram_empty,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wgray,
  input logic [DW-1:0] dout
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (mrst || prst)
    (full && wen) |=> $stable(wbin));

  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (mrst || prst)
    (ram_empty && !rt) |=> $stable(rbin));

  assert_gray_step_R1: assert property (@(posedge wclk) disable iff (mrst || prst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_hf_on_full_R4: assert property (@(posedge wclk) disable iff (mrst || prst)
    full |-> hf);

  assert_paf_on_full_R5: assert property (@(posedge wclk) disable iff (mrst || prst)
    (full && !fasync) |-> paf);

  assert_fwft_hold_R8: assert property (@(posedge rclk) disable iff (mrst || prst)
    (fwft && ovalid && !ren && !rt) |=> $stable(dout));

  assert_mode_latch_R9: assert property (@(posedge wclk) disable iff (prst)
    mrst |=> (fwft == $past(fwft_sel)));
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
  .wen(wen), .ren(ren), .rt(rt), .full(full), .hf(hf), .paf(paf),
  .fasync(fasync), .fwft(fwft), .ovalid(ovalid), .ram_empty(ram_empty),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .dout(dout)
);

// File: tb/sim_dcfifo_pflags.sv
module sim_dcfifo_pflags;
  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0, fwft_sel = 0, flag_async_sel = 0;
  logic [2:0] preset_sel = 3'd1;
  logic wen = 0, ld = 0, sen = 0, si = 0, ren = 0, rt = 0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic rflag, wflag, hf, pae, paf;
  int tests = 0, fails = 0;

  always #5 wclk = ~wclk;
  initial begin #3; forever #7 rclk = ~rclk; end

  dcfifo_pflags #(.DW(9), .AW(4)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .flag_async_sel(flag_async_sel), .preset_sel(preset_sel), .wen(wen), .din(din),
    .ld(ld), .sen(sen), .si(si), .ren(ren), .rt(rt), .dout(dout), .rflag(rflag),
    .wflag(wflag), .hf(hf), .pae(pae), .paf(paf));

  task automatic check(string what, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic do_mreset(input logic fw, input logic as, input logic [2:0] sel);
    @(negedge wclk);
    fwft_sel = fw; flag_async_sel = as; preset_sel = sel; mrst = 1;
    repeat (4) @(negedge wclk);
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    mrst = 0;
    settle();
  endtask

  task automatic do_prst();
    @(negedge wclk); prst = 1;
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst = 0;
    settle();
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge wclk); wen = 1; din = d;
    @(negedge wclk); wen = 0;
  endtask

  task automatic rd();
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
  endtask

  task automatic t_reset();
    do_mreset(0, 0, 3'd1);
    check("R9 empty after mrst", rflag, 1);
    check("R9 not full after mrst", wflag, 0);
    check("R9 hf after mrst", hf, 0);
    check("R5 pae after mrst", pae, 1);
    check("R9 paf after mrst", paf, 0);
  endtask

  task automatic t_order();
    logic [8:0] last;
    do_mreset(0, 0, 3'd1);
    for (int i = 0; i < 5; i++) wr(9'h11 + 9'(i));
    settle();
    check("R2 not empty", rflag, 0);
    for (int i = 0; i < 5; i++) begin
      rd();
      check("R1 order", dout, 9'h11 + 9'(i));
    end
    settle();
    check("R2 empty after drain", rflag, 1);
    last = dout;
    rd();
    check("R2 read while empty ignored", dout, last);
    wr(9'h0AB);
    settle();
    rd();
    check("R2 pointer kept after empty read", dout, 9'h0AB);
  endtask

  task automatic t_full();
    do_mreset(0, 0, 3'd1);
    for (int i = 0; i < 8; i++) wr(9'(i));
    settle();
    check("R4 hf at half", hf, 0);
    wr(9'd8);
    settle();
    check("R4 hf above half", hf, 1);
    for (int i = 9; i < 13; i++) wr(9'(i));
    settle();
    check("R5 paf at 13", paf, 0);
    wr(9'd13);
    settle();
    check("R5 paf at 14", paf, 1);
    wr(9'd14); wr(9'd15);
    settle();
    check("R3 full", wflag, 1);
    wr(9'h1AA);
    settle();
    for (int i = 0; i < 16; i++) begin
      rd();
      check("R3 content after dropped write", dout, i);
      if (i == 12) check("R5 pae with 3 left", pae, 0);
      if (i == 13) check("R5 pae with 2 left", pae, 1);
    end
    settle();
    check("R3 dropped write not stored", rflag, 1);
  endtask

  task automatic t_preset7();
    do_mreset(0, 0, 3'd7);
    for (int i = 0; i < 8; i++) wr(9'(i));
    settle();
    check("R5 preset7 pae at 8", pae, 1);
    check("R5 preset7 paf at 8", paf, 1);
    wr(9'd8);
    settle();
    check("R5 preset7 pae at 9", pae, 0);
  endtask

  task automatic t_parallel();
    do_mreset(0, 0, 3'd0);
    @(negedge wclk); ld = 1; wen = 1; din = 9'd5;
    @(negedge wclk); din = 9'd3;
    @(negedge wclk); wen = 0; ld = 0;
    settle();
    check("R6 load not stored", rflag, 1);
    for (int i = 0; i < 5; i++) wr(9'(i));
    settle();
    check("R6 pae at 5", pae, 1);
    wr(9'd5);
    settle();
    check("R6 pae at 6", pae, 0);
    for (int i = 6; i < 12; i++) wr(9'(i));
    settle();
    check("R6 paf at 12", paf, 0);
    wr(9'd12);
    settle();
    check("R6 paf at 13", paf, 1);
  endtask

  task automatic t_serial();
    logic [7:0] bits;
    bits = 8'b0011_0110;
    do_mreset(0, 0, 3'd0);
    for (int i = 7; i >= 0; i--) begin
      @(negedge wclk); ld = 1; sen = 1; si = bits[i];
    end
    @(negedge wclk); ld = 0; sen = 0; si = 0;
    for (int i = 0; i < 3; i++) wr(9'(i));
    settle();
    check("R7 pae at 3", pae, 1);
    wr(9'd3);
    settle();
    check("R7 pae at 4", pae, 0);
    for (int i = 4; i < 9; i++) wr(9'(i));
    settle();
    check("R7 paf at 9", paf, 0);
    wr(9'd9);
    settle();
    check("R7 paf at 10", paf, 1);
    do_prst();
    check("R9 prst empties", rflag, 1);
    for (int i = 0; i < 3; i++) wr(9'(i));
    settle();
    check("R9 prst keeps empty offset", pae, 1);
    wr(9'd3);
    settle();
    check("R9 prst keeps empty offset above", pae, 0);
  endtask

  task automatic t_fwft();
    do_mreset(1, 0, 3'd1);
    check("R8 not ready when empty", rflag, 0);
    check("R8 input ready", wflag, 1);
    wr(9'h021);
    settle();
    check("R8 ready without read", rflag, 1);
    check("R8 word falls through", dout, 9'h021);
    wr(9'h022);
    settle();
    check("R8 first word held", dout, 9'h021);
    rd();
    check("R8 next word after read", dout, 9'h022);
    rd();
    settle();
    check("R8 not ready after drain", rflag, 0);
    do_prst();
    check("R9 prst clears ready", rflag, 0);
    wr(9'h033);
    settle();
    check("R9 prst keeps fall-through mode", rflag, 1);
    check("R9 fall-through data after prst", dout, 9'h033);
  endtask

  task automatic t_retransmit();
    do_mreset(0, 0, 3'd1);
    for (int i = 0; i < 4; i++) wr(9'h0A0 + 9'(i));
    settle();
    rd(); check("R10 first read", dout, 9'h0A0);
    rd(); check("R10 second read", dout, 9'h0A1);
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    for (int i = 0; i < 4; i++) begin
      rd();
      check("R10 replay", dout, 9'h0A0 + 9'(i));
    end
    wr(9'h0B0);
    settle();
    check("R10 write side not full", wflag, 0);
    rd();
    check("R10 write pointer kept", dout, 9'h0B0);
  endtask

  task automatic fill14_and_probe(input logic as, input int exp_now);
    do_mreset(0, as, 3'd1);
    for (int i = 0; i < 14; i++) wr(9'(i));
    settle();
    check("R11 paf before read", paf, 1);
    @(negedge rclk); ren = 1;
    @(posedge rclk); #1;
    check(as ? "R11 async paf follows read" : "R11 sync paf delayed", paf, exp_now);
    @(negedge rclk); ren = 0;
    settle();
    check("R11 paf after sync", paf, 0);
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_full();
    t_preset7();
    t_parallel();
    t_serial();
    t_fwft();
    t_retransmit();
    fill14_and_probe(1'b1, 0);
    fill14_and_probe(1'b0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule